// File: doc/BRIEF.md
# Doubleword Add/Subtract Unit with Overflow Trap

This block is the integer add/subtract unit of a 64-bit datapath. It carries out four doubleword operations on two source operands, `srcS` and `srcT`: an add that traps, an add that wraps, a subtract that traps and a subtract that wraps. Subtraction always computes `srcS - srcT`, so `srcT` is the subtrahend. The unit registers every result, and all outputs appear one clock after the valid strobe.

The trapping forms check for two's-complement overflow. When it occurs, the unit raises the exception flag and holds the write enable low, so the destination register keeps its old value. The wrapping forms give the same bit pattern modulo 2^DATA_W and always assert the write enable. Instruction fetch, decode, the register file and exception handling are outside the block.

Top module: `dw_addsub_unit`

## Requirements
- R1: While reset (`rstN` low) is asserted, and in the first cycle after it, `result`, `wrEn` and `ovfExc` are all zero.
- R2: With `opSel` = 2'b00 (trapping add) and `inValid` high, `result` one cycle later equals `srcS + srcT` modulo 2^DATA_W.
- R3: With `opSel` = 2'b01 (wrapping add), `result` one cycle later equals `srcS + srcT` modulo 2^DATA_W, and `ovfExc` stays low.
- R4: With `opSel` = 2'b10 (trapping subtract), `result` one cycle later equals `srcS - srcT` modulo 2^DATA_W.
- R5: With `opSel` = 2'b11 (wrapping subtract), `result` one cycle later equals `srcS - srcT` modulo 2^DATA_W, and `ovfExc` stays low.
- R6: A trapping add whose true signed sum lies outside the signed DATA_W-bit range sets `ovfExc` high and `wrEn` low one cycle later.
- R7: A trapping subtract whose true signed difference lies outside the signed DATA_W-bit range sets `ovfExc` high and `wrEn` low one cycle later.
- R8: Every valid operation that does not overflow, and every wrapping operation, sets `wrEn` high and `ovfExc` low one cycle later.
- R9: A cycle with `inValid` low gives `wrEn` and `ovfExc` low one cycle later and leaves `result` unchanged.
- R10: `wrEn` and `ovfExc` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| opSel | input | 2 | 00 trapping add, 01 wrapping add, 10 trapping subtract, 11 wrapping subtract |
| srcS | input | DATA_W | First operand (minuend for subtract) |
| srcT | input | DATA_W | Second operand (subtrahend for subtract) |
| result | output | DATA_W | Registered sum or difference |
| wrEn | output | 1 | Destination write enable |
| ovfExc | output | 1 | Overflow exception |

## Verification
On every cycle the assertions check the arithmetic value for each operation class, that wrapping forms never trap, that idle cycles keep the result and stay quiet, and that write and exception never coincide. They do not state when a signed result overflows. The bench settles that against integer arithmetic by sweeping every operand pair and every operation at a narrow DATA_W, which covers the exact range boundaries at both signs. The bench also checks the reset state and that the result holds across idle cycles placed between operations.

// File: rtl/dw_addsub_pkg.sv
package dw_addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD_TRAP = 2'b00,
    OP_ADD_WRAP = 2'b01,
    OP_SUB_TRAP = 2'b10,
    OP_SUB_WRAP = 2'b11
  } addSubOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic subtract;
    logic trapOn;
  } dpCtrl_t;

endpackage

// File: rtl/dw_addsub_ctrl.sv
module dw_addsub_ctrl
  import dw_addsub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       ovfRaw,
  output dpCtrl_t    ctrl,
  output logic       wrEn,
  output logic       ovfExc
);

  addSubOp_e opCode;
  logic      trapHit;

  always_comb begin
    opCode        = addSubOp_e'(opSel);
    ctrl.load     = inValid;
    ctrl.subtract = (opCode == OP_SUB_TRAP) || (opCode == OP_SUB_WRAP);
    ctrl.trapOn   = (opCode == OP_ADD_TRAP) || (opCode == OP_SUB_TRAP);
    trapHit       = inValid && ctrl.trapOn && ovfRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      ovfExc <= 1'b0;
    end else begin
      wrEn   <= inValid && !trapHit;
      ovfExc <= trapHit;
    end
  end

endmodule

// File: rtl/dw_addsub_dp.sv
module dw_addsub_dp
  import dw_addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] srcS,
  input  logic [DATA_W-1:0] srcT,
  output logic              ovfRaw,
  output logic [DATA_W-1:0] result
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] carryIn;
  logic [DATA_W-1:0] rawSum;

  always_comb begin
    opB     = ctrl.subtract ? ~srcT : srcT;
    carryIn = {{(DATA_W-1){1'b0}}, ctrl.subtract};
    rawSum  = srcS + opB + carryIn;
    // same-sign effective operands yielding opposite-sign sum
    ovfRaw  = (srcS[MSB] == opB[MSB]) && (rawSum[MSB] != srcS[MSB]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (ctrl.load) begin
      result <= rawSum;
    end
  end

endmodule

// File: rtl/dw_addsub_unit.sv
module dw_addsub_unit
  import dw_addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] srcS,
  input  logic [DATA_W-1:0] srcT,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              ovfExc
);

  dpCtrl_t ctrl;
  logic    ovfRaw;

  dw_addsub_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .opSel  (opSel),
    .ovfRaw (ovfRaw),
    .ctrl   (ctrl),
    .wrEn   (wrEn),
    .ovfExc (ovfExc)
  );

  dw_addsub_dp #(.DATA_W(DATA_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .srcS  (srcS),
    .srcT  (srcT),
    .ovfRaw(ovfRaw),
    .result(result)
  );

endmodule

// File: rtl/dw_addsub_chk.sv
module dw_addsub_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        opSel,
  input logic [DATA_W-1:0] srcS,
  input logic [DATA_W-1:0] srcT,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              ovfExc
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!wrEn && !ovfExc)); // R1

  AST_ADD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel[1]) |=> (result == DATA_W'($past(srcS) + $past(srcT)))); // R2

  AST_WRAP_ADD_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b01) |=> !ovfExc); // R3

  AST_SUB_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel[1]) |=> (result == DATA_W'($past(srcS) - $past(srcT)))); // R4

  AST_WRAP_SUB_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b11) |=> !ovfExc); // R5

  AST_VALID_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (wrEn || ovfExc)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!wrEn && !ovfExc && $stable(result))); // R9

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && ovfExc)); // R10

endmodule

bind dw_addsub_unit dw_addsub_chk #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .inValid(inValid),
  .opSel  (opSel),
  .srcS   (srcS),
  .srcT   (srcT),
  .result (result),
  .wrEn   (wrEn),
  .ovfExc (ovfExc)
);

// File: tb/dw_addsub_unit_tb_top.sv
module dw_addsub_unit_tb_top;

  localparam int W    = 5;
  localparam int SPAN = 1 << W;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] srcS = '0;
  logic [W-1:0] srcT = '0;
  logic [W-1:0] result;
  logic         wrEn;
  logic         ovfExc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dw_addsub_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .srcS(srcS), .srcT(srcT), .result(result), .wrEn(wrEn), .ovfExc(ovfExc)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int toSigned(input int v);
    return (v > SMAX) ? v - SPAN : v;
  endfunction

  task automatic runOp(input int op, input int a, input int b);
    int sa, sb, trueVal, expRes;
    bit isSub, trap, ovf;
    isSub = op[1];
    trap  = !op[0];
    sa = toSigned(a);
    sb = toSigned(b);
    trueVal = isSub ? sa - sb : sa + sb;
    expRes  = (isSub ? a - b : a + b) & (SPAN - 1);
    ovf = (trueVal > SMAX) || (trueVal < SMIN);
    opSel   = op[1:0];
    srcS    = a[W-1:0];
    srcT    = b[W-1:0];
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    case (op)
      0: check("R2 add value", int'(result), expRes);
      1: check("R3 wrapping add value", int'(result), expRes);
      2: check("R4 sub value", int'(result), expRes);
      default: check("R5 wrapping sub value", int'(result), expRes);
    endcase
    if (trap && ovf) begin
      check(isSub ? "R7 sub trap flag" : "R6 add trap flag", int'(ovfExc), 1);
      check(isSub ? "R7 sub write blocked" : "R6 add write blocked", int'(wrEn), 0);
    end else begin
      check(op[0] ? "R3 R5 wrapping no trap" : "R8 no trap", int'(ovfExc), 0);
      check("R8 write enable", int'(wrEn), 1);
    end
    check("R10 exclusive strobes", int'(wrEn && ovfExc), 0);
  endtask

  task automatic idleCycle();
    logic [W-1:0] held;
    held = result;
    inValid = 1'b0;
    srcS = ~srcS;
    srcT = srcT + 1'b1;
    @(negedge clk);
    check("R9 idle result holds", int'(result), int'(held));
    check("R9 idle write low", int'(wrEn), 0);
    check("R9 idle exc low", int'(ovfExc), 0);
  endtask

  initial begin
    @(negedge clk);
    check("R1 reset result", int'(result), 0);
    check("R1 reset wrEn", int'(wrEn), 0);
    check("R1 reset ovfExc", int'(ovfExc), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset wrEn", int'(wrEn), 0);
    check("R1 post-reset ovfExc", int'(ovfExc), 0);
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          runOp(op, a, b);
          if (((a + b) % 7) == 0) idleCycle();
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule